// File: doc/BRIEF.md
# Floating-Point Register Push Sequencer

This block carries out the memory side of a push of floating-point registers onto a descending stack. It takes the decoded fields of the instruction: a precision select, a 4-bit register field, a 1-bit register extension bit and an 8-bit word count. It also takes the current stack pointer and has a read port into a file of 32 single-precision words. It checks the register list. If the list is legal, the block lowers the stack pointer by four bytes per word. It then writes one 32-bit word per beat over a valid/ready store port, at ascending addresses, and finally writes the lowered stack pointer back.

In single precision the starting word is the register field followed by the extension bit as its low bit. In double precision the starting double register is the extension bit followed by the register field. Double register n occupies words 2n (low half) and 2n+1 (high half). An illegal list raises a one-cycle flag and changes nothing. The number of cycles a push takes depends only on the count and on the ready pattern, never on the data stored.

The controller has four states. ST_IDLE waits for `start`. ST_FETCH reads one word from the register file. ST_ISSUE presents one store. ST_FINISH writes the stack pointer back. The transitions are:
- ST_IDLE to ST_FETCH on a legal start.
- ST_FETCH to ST_ISSUE always.
- ST_ISSUE to ST_FETCH when a beat that is not the last is accepted.
- ST_ISSUE to ST_FINISH when the last beat is accepted.
- ST_FINISH to ST_IDLE always.

An illegal start leaves the controller in ST_IDLE.

Top module: `fpush_seq`

## Requirements
- R1: In single precision (`dbl_mode`=0) the first word is {fld_vd, fld_d}, and beat k stores register-file word first+k. There are exactly fld_cnt beats.
- R2: In double precision (`dbl_mode`=1) the first word is 2*{fld_d, fld_vd}. Each double register is stored as two beats, low word (even index) first at the lower address. There are exactly fld_cnt beats.
- R3: The new stack pointer is sp_in - 4*fld_cnt. Beat k goes to address new_sp + 4*k.
- R4: A start is illegal in any of these cases: fld_cnt=0; in double precision fld_cnt is odd or above 32; first+fld_cnt exceeds 32. An illegal start raises `illegal` for exactly one cycle, on the cycle after start. It issues no store, does not assert `sp_we` and leaves `busy` low.
- R5: While `st_valid` is high and `st_ready` is low, `st_valid`, `st_addr` and `st_data` hold their values.
- R6: `busy` is high from the cycle after a legal start through the cycle in which the last beat is accepted, and low at all other times.
- R7: On the cycle after the last beat is accepted, `done` and `sp_we` pulse high for exactly one cycle, with `sp_out` equal to the new stack pointer.
- R8: With `st_ready` held high, `done` rises exactly 2*fld_cnt+1 cycles after the start cycle, whatever data is stored. Each cycle in which ready is low adds one cycle.
- R9: A `start` that arrives while `busy` is high is ignored: the push in progress completes unchanged, and no further stores or pulses follow.
- R10: During and after reset, `busy`, `done`, `sp_we`, `illegal` and `st_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a push using the field inputs |
| dbl_mode | input | 1 | 1 = double precision, 0 = single precision |
| fld_vd | input | 4 | Register field of the first register |
| fld_d | input | 1 | Register extension bit |
| fld_cnt | input | 8 | Number of 32-bit words to push |
| sp_in | input | 32 | Current stack pointer |
| rf_idx | output | 5 | Register-file word index being read |
| rf_rdata | input | 32 | Register-file read data for rf_idx (combinational) |
| st_valid | output | 1 | Store beat valid |
| st_ready | input | 1 | Store beat accepted when high with st_valid |
| st_addr | output | 32 | Store byte address |
| st_data | output | 32 | Store data word |
| sp_we | output | 1 | Stack-pointer writeback strobe |
| sp_out | output | 32 | Stack-pointer writeback value |
| busy | output | 1 | Push in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-list pulse |

## Verification
A corrupted word index or beat counter shows up at the store port on the very beat it affects. The scoreboard then sees a wrong data word, a wrong address, a missing beat or an extra beat. A corrupted state register shows up within one or two cycles as `busy` disagreeing with the store handshake, or as a `done` pulse at the wrong point. That point is caught by the exact latency check on unstalled pushes. A faulty legality decision shows up either as a store after an illegal start or as a missing `illegal` pulse on the cycle after start.

// File: rtl/fpush_pkg.sv
package fpush_pkg;
    localparam int FP_NWORDS    = 32;
    localparam int FP_MAX_DBL   = 16;
    localparam int FP_CNT_W     = 8;
    localparam int FP_ADDR_W    = 32;
    localparam int FP_DATA_W    = 32;
    localparam int FP_IDX_W     = $clog2(FP_NWORDS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ISSUE,
        ST_FINISH
    } fpush_state_e;
endpackage

// File: rtl/fpush_decode.sv
module fpush_decode
    import fpush_pkg::*;
#(
    parameter int NWORDS  = FP_NWORDS,
    parameter int MAX_DBL = FP_MAX_DBL,
    parameter int CNT_W   = FP_CNT_W,
    parameter int ADDR_W  = FP_ADDR_W,
    localparam int IDX_W  = $clog2(NWORDS),
    localparam int SUM_W  = CNT_W + 2
) (
    input  logic              dbl_mode,
    input  logic [3:0]        fld_vd,
    input  logic              fld_d,
    input  logic [CNT_W-1:0]  fld_cnt,
    input  logic [ADDR_W-1:0] sp_in,
    output logic [IDX_W-1:0]  first_word,
    output logic              legal,
    output logic [ADDR_W-1:0] new_sp
);
    // Starting word index, one bit wider than the file so a double
    // register past the last pair is still visible as out of range.
    logic [5:0]       start_w;
    logic [SUM_W-1:0] end_w;
    logic             cnt_ok;
    logic             dbl_ok;
    logic             range_ok;

    always_comb begin
        if (dbl_mode) start_w = {fld_d, fld_vd, 1'b0};
        else          start_w = {1'b0, fld_vd, fld_d};
        end_w    = SUM_W'(start_w) + SUM_W'(fld_cnt);
        cnt_ok   = (fld_cnt != '0);
        dbl_ok   = !dbl_mode || (!fld_cnt[0] && (int'(fld_cnt) <= 2 * MAX_DBL));
        range_ok = (int'(end_w) <= NWORDS);
        legal    = cnt_ok && dbl_ok && range_ok;
        first_word = start_w[IDX_W-1:0];
        new_sp   = sp_in - (ADDR_W'(fld_cnt) << 2);
    end
endmodule

// File: rtl/fpush_beat_ctr.sv
module fpush_beat_ctr
    import fpush_pkg::*;
#(
    parameter int NWORDS = FP_NWORDS,
    parameter int CNT_W  = FP_CNT_W,
    localparam int IDX_W = $clog2(NWORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             advance,
    output logic [IDX_W-1:0] word_idx,
    output logic             last_beat
);
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            left_q <= '0;
        end else if (load) begin
            idx_q  <= load_idx;
            left_q <= load_cnt;
        end else if (advance) begin
            idx_q  <= idx_q + 1'b1;
            left_q <= left_q - 1'b1;
        end
    end

    assign word_idx  = idx_q;
    assign last_beat = (left_q == CNT_W'(1));

    // A beat is accepted only while words remain (R8 beat count).
    p_no_underrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (left_q != '0));
    // Load and advance never coincide: a new push starts only from idle.
    p_load_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && advance));
endmodule

// File: rtl/fpush_seq.sv
module fpush_seq
    import fpush_pkg::*;
#(
    parameter int NWORDS  = FP_NWORDS,
    parameter int MAX_DBL = FP_MAX_DBL,
    parameter int CNT_W   = FP_CNT_W,
    parameter int ADDR_W  = FP_ADDR_W,
    parameter int DATA_W  = FP_DATA_W,
    localparam int IDX_W  = $clog2(NWORDS),
    localparam int WORD_BYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dbl_mode,
    input  logic [3:0]        fld_vd,
    input  logic              fld_d,
    input  logic [CNT_W-1:0]  fld_cnt,
    input  logic [ADDR_W-1:0] sp_in,
    output logic [IDX_W-1:0]  rf_idx,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              st_valid,
    input  logic              st_ready,
    output logic [ADDR_W-1:0] st_addr,
    output logic [DATA_W-1:0] st_data,
    output logic              sp_we,
    output logic [ADDR_W-1:0] sp_out,
    output logic              busy,
    output logic              done,
    output logic              illegal
);
    fpush_state_e state_q, state_d;

    logic [IDX_W-1:0]  dec_first;
    logic              dec_legal;
    logic [ADDR_W-1:0] dec_new_sp;
    logic              last_beat;
    logic              take_start;
    logic              beat_accept;
    logic [ADDR_W-1:0] new_sp_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              illegal_q;

    fpush_decode #(
        .NWORDS(NWORDS), .MAX_DBL(MAX_DBL), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
    ) u_decode (
        .dbl_mode  (dbl_mode),
        .fld_vd    (fld_vd),
        .fld_d     (fld_d),
        .fld_cnt   (fld_cnt),
        .sp_in     (sp_in),
        .first_word(dec_first),
        .legal     (dec_legal),
        .new_sp    (dec_new_sp)
    );

    assign take_start  = (state_q == ST_IDLE) && start;
    assign beat_accept = (state_q == ST_ISSUE) && st_ready;

    fpush_beat_ctr #(.NWORDS(NWORDS), .CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_start && dec_legal),
        .load_idx (dec_first),
        .load_cnt (fld_cnt),
        .advance  (beat_accept),
        .word_idx (rf_idx),
        .last_beat(last_beat)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: timing depends only on count and ready, not on data.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start && dec_legal) state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_ISSUE;
            ST_ISSUE:  if (st_ready) state_d = last_beat ? ST_FINISH : ST_FETCH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_sp_q  <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= take_start && !dec_legal;
            if (take_start && dec_legal) begin
                new_sp_q <= dec_new_sp;
                addr_q   <= dec_new_sp;
            end
            if (state_q == ST_FETCH) data_q <= rf_rdata;
            if (beat_accept) addr_q <= addr_q + ADDR_W'(WORD_BYTES);
        end
    end

    // Outputs.
    always_comb begin
        st_valid = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        sp_we    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_FETCH:  busy = 1'b1;
            ST_ISSUE:  begin busy = 1'b1; st_valid = 1'b1; end
            ST_FINISH: begin done = 1'b1; sp_we = 1'b1; end
            default:   ;
        endcase
        st_addr = addr_q;
        st_data = data_q;
        sp_out  = new_sp_q;
        illegal = illegal_q;
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_addr) && $stable(st_data)));
    p_valid_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> busy);
    p_done_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(st_valid && st_ready));
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_illegal_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy && !st_valid && !sp_we));
    p_illegal_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal || $past(start));
endmodule

// File: tb/tb_fpush_seq.sv
module tb_fpush_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dbl_mode = 1'b0;
    logic [3:0]  fld_vd = '0;
    logic        fld_d = 1'b0;
    logic [7:0]  fld_cnt = '0;
    logic [31:0] sp_in = '0;
    logic [4:0]  rf_idx;
    logic [31:0] rf_rdata;
    logic        st_valid;
    logic        st_ready = 1'b1;
    logic [31:0] st_addr;
    logic [31:0] st_data;
    logic        sp_we;
    logic [31:0] sp_out;
    logic        busy;
    logic        done;
    logic        illegal;

    logic [31:0] rf [32];
    assign rf_rdata = rf[rf_idx];

    typedef struct packed { logic [31:0] a; logic [31:0] d; } exp_t;
    exp_t   exp_q[$];
    int     n_checks = 0;
    int     n_errors = 0;
    int     cyc = 0;
    bit     stall_en = 1'b0;
    int     rdy_cnt = 0;
    string  tag = "R10";

    fpush_seq dut (.*);

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    // Ready driver.
    always @(negedge clk) begin
        rdy_cnt++;
        st_ready = stall_en ? ((rdy_cnt % 3) != 0) : 1'b1;
    end

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n && st_valid && st_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4/R9", "unexpected store addr", st_addr, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(st_addr == e.a, "R3", "store address", st_addr, e.a);
                check(st_data == e.d, tag, "store data", st_data, e.d);
            end
        end
    end

    task automatic fill_rf(input logic [31:0] seed);
        for (int i = 0; i < 32; i++) rf[i] = seed ^ (32'h0101_0101 * i) ^ i;
    endtask

    // Drive one push, predict everything from the requirements, and check.
    task automatic do_push(input bit dbl, input logic [3:0] vd, input bit d,
                           input logic [7:0] cnt, input logic [31:0] sp,
                           input bit stall, input bit poke);
        int  first;
        bit  legal;
        logic [31:0] nsp;
        int  lat;
        bit  busy_ok;
        first = dbl ? 2 * ((int'(d) << 4) | int'(vd)) : ((int'(vd) << 1) | int'(d));
        legal = (cnt != 0) && (!dbl || (cnt[0] == 1'b0 && cnt <= 32)) && (first + cnt <= 32);
        nsp   = sp - 32'(cnt) * 4;
        tag   = dbl ? "R2" : "R1";
        if (legal) for (int k = 0; k < cnt; k++) exp_q.push_back({nsp + 32'(4 * k), rf[first + k]});
        stall_en = stall;
        @(negedge clk);
        dbl_mode = dbl; fld_vd = vd; fld_d = d; fld_cnt = cnt; sp_in = sp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!legal) begin
            check(illegal == 1'b1, "R4", "illegal pulse", illegal, 1);
            check(busy == 1'b0, "R4", "busy on illegal", busy, 0);
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                check(!illegal && !sp_we && !busy && !st_valid, "R4",
                      "quiet after illegal", {illegal, sp_we, busy, st_valid}, 0);
            end
            return;
        end
        check(illegal == 1'b0, "R4", "no illegal on legal list", illegal, 0);
        lat = 1;
        busy_ok = 1'b1;
        while (!done && lat < 2000) begin
            if (!busy) busy_ok = 1'b0;
            if (poke && lat == 3) begin
                fld_cnt = 8'd1; fld_vd = 4'd0; dbl_mode = 1'b0; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check(busy_ok, "R6", "busy through push", busy_ok, 1);
        check(busy == 1'b0, "R6", "busy low at done", busy, 0);
        check(done && sp_we, "R7", "done and sp_we", {done, sp_we}, 2'b11);
        check(sp_out == nsp, "R7", "sp writeback", sp_out, nsp);
        check(exp_q.size() == 0, tag, "beats left unissued", exp_q.size(), 0);
        if (!stall) check(lat == 2 * cnt + 1, "R8", "latency", lat, 2 * cnt + 1);
        @(negedge clk);
        check(!done && !sp_we, "R7", "single-cycle done", {done, sp_we}, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!busy && !st_valid && !done, "R9", "idle after push",
                  {busy, st_valid, done}, 0);
        end
        exp_q.delete();
    endtask

    initial begin
        fill_rf(32'hA5A5_0000);
        repeat (3) @(negedge clk);
        check(!busy && !done && !sp_we && !illegal && !st_valid, "R10",
              "reset outputs", {busy, done, sp_we, illegal, st_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !st_valid, "R10", "idle after reset", {busy, st_valid}, 0);

        do_push(1'b0, 4'd2,  1'b1, 8'd3,  32'h0000_1000, 1'b0, 1'b0); // R1 first=5
        do_push(1'b1, 4'd3,  1'b0, 8'd4,  32'h0000_2000, 1'b0, 1'b0); // R2 D3..D4
        do_push(1'b1, 4'd15, 1'b0, 8'd2,  32'h0000_3004, 1'b0, 1'b0); // R2 last pair
        do_push(1'b1, 4'd0,  1'b0, 8'd32, 32'h0000_8000, 1'b0, 1'b0); // R2 16 regs
        do_push(1'b0, 4'd15, 1'b1, 8'd1,  32'h0000_0010, 1'b0, 1'b0); // R1 word 31
        do_push(1'b0, 4'd0,  1'b0, 8'd32, 32'h0001_0000, 1'b1, 1'b0); // R5 stalls
        do_push(1'b1, 4'd1,  1'b0, 8'd6,  32'h0000_4000, 1'b1, 1'b0); // R5 stalls
        // R8: same push with inverted data must take the same time.
        fill_rf(32'hFFFF_FFFF);
        do_push(1'b0, 4'd2,  1'b1, 8'd3,  32'h0000_1000, 1'b0, 1'b0);
        fill_rf(32'h0000_0000);
        do_push(1'b0, 4'd2,  1'b1, 8'd3,  32'h0000_1000, 1'b0, 1'b0);
        // R9: start during busy is ignored.
        fill_rf(32'h1234_5678);
        do_push(1'b0, 4'd4,  1'b0, 8'd5,  32'h0000_5000, 1'b0, 1'b1);
        // R4 illegal lists.
        do_push(1'b0, 4'd0,  1'b0, 8'd0,  32'h0000_6000, 1'b0, 1'b0);
        do_push(1'b1, 4'd0,  1'b0, 8'd3,  32'h0000_6000, 1'b0, 1'b0);
        do_push(1'b1, 4'd0,  1'b0, 8'd34, 32'h0000_6000, 1'b0, 1'b0);
        do_push(1'b0, 4'd15, 1'b0, 8'd3,  32'h0000_6000, 1'b0, 1'b0);
        do_push(1'b1, 4'd0,  1'b1, 8'd2,  32'h0000_6000, 1'b0, 1'b0);
        // Legal push after illegal ones still works.
        do_push(1'b1, 4'd7,  1'b0, 8'd2,  32'h0000_7000, 1'b0, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule